// File: doc/BRIEF.md
# Protection Fault Response Controller

This block sits behind the analog front end of a power-path switch. It receives fault flags that have already been compared and filtered, and decides how the switch reacts to each one. The reaction is one of three: turn the switch off, ask for current limiting, or do nothing. For each fault it also decides whether the open-drain fault indication is pulled low and whether the fault is held after its flag goes away. Held faults recover by an automatic retry or stay off, depending on a variant select.

A device runs either as a primary/standalone unit or as a secondary in a chain of parallel switches. A secondary reports its own held faults by pulling the shared synchronisation line low for a short pulse and leaves the response to the primary. If the primary never answers by pulling the line low itself, the secondary falls back to a failsafe: it holds the line low, which turns off the whole chain. Only a collapse of the bias supply or a drop of the enable pin below its shutdown level clears a held fault.

Top module: `pfr_fault_ctrl`

## Requirements
- R1: While reset is low and after it is released, faultCause is 0, fltN is 1 and syncPullDown is 0. With supplies in range and no flags, swEn is 1. startReq is 1 for exactly the cycle in which swEn is 1 and was 0 in the previous cycle.
- R2: The held-fault flags are faultFlags bit 0 (overtemperature), 1 (steady-state overcurrent), 3 (short circuit, primary mode only), 4 (monitor pin open), 5 (monitor pin short), 6 (reference pin open), 7 (reference pin short), 8 (timer pin high), 9 (start-up timeout), 10 (gate-source health), 11 (gate-drain health) and 13 (sync line sensed low). In primary mode, from the cycle after such a flag is seen, swEn is 0 and fltN is 0. Both hold after the flag drops, and faultCause stays non-zero for as long as the fault is held.
- R3: Any of the following turns swEn off without holding the fault, and fltN stays 1: enAboveUvlo is 0, biasOk is 0, vinOk is 0, or vinOv is 1. When the condition ends, swEn returns with a startReq pulse.
- R4: faultFlags bit 2 (overcurrent during start-up) sets ilimReq and pulls fltN low for as long as it is present. swEn stays on and nothing is held.
- R5: faultFlags bit 12 (drain-source health) turns swEn off and pulls fltN low only for as long as the flag is present.
- R6: In secondary mode (modeSecondary=1), faultFlags bit 3 turns swEn off and sets ilimReq while present. fltN stays 1 and nothing is held.
- R7: A low sync line (bit 13) counts as a fault only while no undervoltage or overvoltage condition from R3 is present.
- R8: In primary mode with autoRetry=1, a held fault releases after RETRY_CYC cycles. swEn comes back with a startReq pulse and faultCause returns to 0. With autoRetry=0 the fault stays held.
- R9: In secondary mode, a held-fault flag other than bit 13 drives syncPullDown for PULSE_CYC cycles, with swEn 0 and fltN 0. The block then waits up to SAFE_CYC cycles. If the sync line is sensed low in that window, the fault is held with syncPullDown 0. Otherwise syncPullDown goes to 1 and stays there (failsafe latch-off).
- R10: A held fault, including the failsafe, clears (faultCause 0, normal operation resumes) in the cycle after biasOk=0 or enAboveShdn=0. enAboveUvlo=0 on its own does not clear it.
- R11: Bit 10 acts only after it has been high for GS_QUAL consecutive cycles, and bit 5 only after IMS_QUAL consecutive cycles.
- R12: faultCause reports the first held cause. The codes are bit 0→1, 1→2, 3→3, 4→4, 5→5, 6→6, 7→7, 8→8, 9→9, 10→10, 11→11 and 13→12. The lowest code wins when several flags arrive together. The value does not change while the fault is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultFlags | input | 14 | Qualified fault flags, bit positions as in R2/R4/R5 |
| modeSecondary | input | 1 | 1 = secondary in a parallel chain, 0 = primary/standalone |
| autoRetry | input | 1 | Variant select: 1 = auto-retry, 0 = latch-off |
| enAboveShdn | input | 1 | Enable pin above its shutdown threshold |
| enAboveUvlo | input | 1 | Enable pin above its undervoltage threshold |
| biasOk | input | 1 | Bias supply above its falling undervoltage threshold |
| vinOk | input | 1 | Input supply above its undervoltage threshold |
| vinOv | input | 1 | Input supply overvoltage |
| swEn | output | 1 | Power switch enable |
| ilimReq | output | 1 | Current-limit request |
| startReq | output | 1 | One-cycle request for a slew-limited start-up |
| fltN | output | 1 | Fault indication, active low |
| syncPullDown | output | 1 | Pull the shared sync line low |
| faultCause | output | 4 | First held fault cause code (R12) |

## Verification
The assertions check on every cycle that the sync line is never pulled while the switch is on, that supply faults always force the switch off, that a start request only comes with the switch on, that a held cause keeps the fault pin low and does not change, and that a clearing event empties the cause. Some behaviours only the bench's scenarios can show: the qualifying windows, the exact lengths of the retry interval, the sync pulse and the failsafe wait, which cause wins among simultaneous flags, and the failsafe against the answered-secondary path. These depend on event order, so the bench runs a cycle-accurate reference model against them.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
  localparam int NUM_FLAGS = 14;
  localparam int NUM_LATCH = 12;

  typedef enum logic [2:0] {
    ST_RUN, ST_LATCH, ST_SIG, ST_WAIT, ST_FAIL
  } ctlState_t;

  typedef enum logic [1:0] {
    TMR_RETRY, TMR_PULSE, TMR_SAFE
  } tmrSel_t;

  typedef struct packed {
    logic    tmrClr;
    logic    capCause;
    logic    clrCause;
    tmrSel_t tmrSel;
  } strobe_t;

  typedef struct packed {
    logic ownHit;
    logic syncHit;
    logic tmrDone;
  } status_t;
endpackage

// File: rtl/pfr_qualifier.sv
module pfr_qualifier #(
  parameter int LIMIT = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic flagIn,
  output logic qualOut
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                       runCnt <= '0;
    else if (!flagIn)                runCnt <= '0;
    else if (runCnt != CW'(LIMIT))   runCnt <= runCnt + 1'b1;
  end

  assign qualOut = (runCnt == CW'(LIMIT));
endmodule

// File: rtl/pfr_datapath.sv
module pfr_datapath
  import pfr_pkg::*;
#(
  parameter int GS_QUAL   = 10,
  parameter int IMS_QUAL  = 30,
  parameter int RETRY_CYC = 20,
  parameter int PULSE_CYC = 4,
  parameter int SAFE_CYC  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LATCH-1:0] rawLatch,
  input  logic                 modeSecondary,
  input  logic                 supplyBad,
  input  strobe_t              strobe,
  output status_t              status,
  output logic [3:0]           faultCause
);
  localparam int MAXA = (RETRY_CYC > PULSE_CYC) ? RETRY_CYC : PULSE_CYC;
  localparam int MAXC = (MAXA > SAFE_CYC) ? MAXA : SAFE_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  logic gsQual, imsQual;
  logic [NUM_LATCH-1:0] latchVec;
  logic [3:0] causeCode;
  logic [TW-1:0] tmrCnt, tmrLast;

  pfr_qualifier #(.LIMIT(IMS_QUAL)) imsQual_i (
    .clk(clk), .rstN(rstN), .flagIn(rawLatch[4]), .qualOut(imsQual));
  pfr_qualifier #(.LIMIT(GS_QUAL)) gsQual_i (
    .clk(clk), .rstN(rstN), .flagIn(rawLatch[9]), .qualOut(gsQual));

  always_comb begin
    latchVec     = rawLatch;
    latchVec[2]  = rawLatch[2] && !modeSecondary;
    latchVec[4]  = imsQual;
    latchVec[9]  = gsQual;
    latchVec[11] = rawLatch[11] && !supplyBad;
  end

  always_comb begin
    causeCode = 4'd0;
    for (int i = NUM_LATCH - 1; i >= 0; i--)
      if (latchVec[i]) causeCode = 4'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrCause) faultCause <= 4'd0;
    else if (strobe.capCause)     faultCause <= causeCode;
  end

  always_comb begin
    unique case (strobe.tmrSel)
      TMR_PULSE: tmrLast = TW'(PULSE_CYC - 1);
      TMR_SAFE:  tmrLast = TW'(SAFE_CYC - 1);
      default:   tmrLast = TW'(RETRY_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.tmrClr) tmrCnt <= '0;
    else                        tmrCnt <= tmrCnt + 1'b1;
  end

  assign status.ownHit  = |latchVec[NUM_LATCH-2:0];
  assign status.syncHit = latchVec[NUM_LATCH-1];
  assign status.tmrDone = (tmrCnt == tmrLast);
endmodule

// File: rtl/pfr_control.sv
module pfr_control
  import pfr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    modeSecondary,
  input  logic    autoRetry,
  input  logic    clearEvt,
  input  logic    supplyBad,
  input  logic    ocStartup,
  input  logic    shortCkt,
  input  logic    fetDs,
  input  logic    syncLow,
  input  status_t status,
  output strobe_t strobe,
  output logic    swEn,
  output logic    ilimReq,
  output logic    startReq,
  output logic    fltN,
  output logic    syncPullDown
);
  ctlState_t state, stateNxt;
  logic swEnPrev, secShort, inRun;

  assign inRun    = (state == ST_RUN);
  assign secShort = modeSecondary && shortCkt;

  always_comb begin
    stateNxt        = state;
    strobe.tmrClr   = inRun || status.tmrDone;
    strobe.capCause = 1'b0;
    strobe.clrCause = 1'b0;
    strobe.tmrSel   = TMR_RETRY;
    unique case (state)
      ST_SIG:  strobe.tmrSel = TMR_PULSE;
      ST_WAIT: strobe.tmrSel = TMR_SAFE;
      default: strobe.tmrSel = TMR_RETRY;
    endcase
    if (clearEvt) begin
      stateNxt        = ST_RUN;
      strobe.clrCause = 1'b1;
      strobe.tmrClr   = 1'b1;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (status.ownHit) begin
            strobe.capCause = 1'b1;
            stateNxt = modeSecondary ? ST_SIG : ST_LATCH;
          end else if (status.syncHit) begin
            strobe.capCause = 1'b1;
            stateNxt = ST_LATCH;
          end
        end
        ST_LATCH: begin
          if (autoRetry && !modeSecondary && status.tmrDone) begin
            stateNxt        = ST_RUN;
            strobe.clrCause = 1'b1;
          end
        end
        ST_SIG:  if (status.tmrDone) stateNxt = ST_WAIT;
        ST_WAIT: begin
          if (syncLow)             stateNxt = ST_LATCH;
          else if (status.tmrDone) stateNxt = ST_FAIL;
        end
        default: stateNxt = ST_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_RUN;
      swEnPrev <= 1'b0;
    end else begin
      state    <= stateNxt;
      swEnPrev <= swEn;
    end
  end

  assign swEn         = inRun && !supplyBad && !fetDs && !secShort;
  assign ilimReq      = inRun && (ocStartup || secShort);
  assign fltN         = inRun && !fetDs && !ocStartup;
  assign syncPullDown = (state == ST_SIG) || (state == ST_FAIL);
  assign startReq     = swEn && !swEnPrev;
endmodule

// File: rtl/pfr_fault_ctrl.sv
module pfr_fault_ctrl
  import pfr_pkg::*;
#(
  parameter int GS_QUAL   = 10,
  parameter int IMS_QUAL  = 30,
  parameter int RETRY_CYC = 20,
  parameter int PULSE_CYC = 4,
  parameter int SAFE_CYC  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] faultFlags,
  input  logic                 modeSecondary,
  input  logic                 autoRetry,
  input  logic                 enAboveShdn,
  input  logic                 enAboveUvlo,
  input  logic                 biasOk,
  input  logic                 vinOk,
  input  logic                 vinOv,
  output logic                 swEn,
  output logic                 ilimReq,
  output logic                 startReq,
  output logic                 fltN,
  output logic                 syncPullDown,
  output logic [3:0]           faultCause
);
  strobe_t strobe;
  status_t status;
  logic clearEvt, supplyBad;
  logic [NUM_LATCH-1:0] rawLatch;

  assign clearEvt  = !biasOk || !enAboveShdn;
  assign supplyBad = clearEvt || !enAboveUvlo || !vinOk || vinOv;
  assign rawLatch  = {faultFlags[13], faultFlags[11:3], faultFlags[1:0]};

  pfr_datapath #(
    .GS_QUAL(GS_QUAL), .IMS_QUAL(IMS_QUAL), .RETRY_CYC(RETRY_CYC),
    .PULSE_CYC(PULSE_CYC), .SAFE_CYC(SAFE_CYC)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .rawLatch(rawLatch), .modeSecondary(modeSecondary),
    .supplyBad(supplyBad), .strobe(strobe), .status(status),
    .faultCause(faultCause));

  pfr_control control_i (
    .clk(clk), .rstN(rstN), .modeSecondary(modeSecondary), .autoRetry(autoRetry),
    .clearEvt(clearEvt), .supplyBad(supplyBad), .ocStartup(faultFlags[2]),
    .shortCkt(faultFlags[3]), .fetDs(faultFlags[12]), .syncLow(faultFlags[13]),
    .status(status), .strobe(strobe), .swEn(swEn), .ilimReq(ilimReq),
    .startReq(startReq), .fltN(fltN), .syncPullDown(syncPullDown));
endmodule

// File: rtl/pfr_fault_ctrl_chk.sv
module pfr_fault_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       modeSecondary,
  input logic       autoRetry,
  input logic       enAboveShdn,
  input logic       biasOk,
  input logic       vinOk,
  input logic       vinOv,
  input logic       swEn,
  input logic       startReq,
  input logic       fltN,
  input logic       syncPullDown,
  input logic [3:0] faultCause
);
  // R9
  sync_pull_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncPullDown |-> (!swEn && !fltN));

  // R3
  supply_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!vinOk || vinOv) |-> !swEn);

  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq |-> swEn);

  // R10
  clear_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!biasOk || !enAboveShdn) |=> (faultCause == 4'd0));

  // R12
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((faultCause != 4'd0) && biasOk && enAboveShdn && (modeSecondary || !autoRetry))
      |=> (faultCause == $past(faultCause)));

  // R2
  held_pin_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (faultCause != 4'd0) |-> (!fltN && !swEn));
endmodule

bind pfr_fault_ctrl pfr_fault_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .modeSecondary(modeSecondary), .autoRetry(autoRetry),
  .enAboveShdn(enAboveShdn), .biasOk(biasOk), .vinOk(vinOk), .vinOv(vinOv),
  .swEn(swEn), .startReq(startReq), .fltN(fltN), .syncPullDown(syncPullDown),
  .faultCause(faultCause));

// File: tb/pfr_fault_ctrl_tb_top.sv
`timescale 1ns/1ps
module pfr_fault_ctrl_tb_top;
  localparam int GSQ = 10, IMSQ = 30, RETRY = 20, PULSE = 4, SAFE = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [13:0] flags = '0;
  logic modeSec = 1'b0, autoRetry = 1'b0;
  logic enShdn = 1'b1, enUvlo = 1'b1, biasOk = 1'b1, vinOk = 1'b1, vinOv = 1'b0;
  logic swEn, ilimReq, startReq, fltN, syncPullDown;
  logic [3:0] faultCause;

  int checks = 0, errors = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  pfr_fault_ctrl #(.GS_QUAL(GSQ), .IMS_QUAL(IMSQ), .RETRY_CYC(RETRY),
    .PULSE_CYC(PULSE), .SAFE_CYC(SAFE)) dut_i (
    .clk(clk), .rstN(rstN), .faultFlags(flags), .modeSecondary(modeSec),
    .autoRetry(autoRetry), .enAboveShdn(enShdn), .enAboveUvlo(enUvlo),
    .biasOk(biasOk), .vinOk(vinOk), .vinOv(vinOv), .swEn(swEn),
    .ilimReq(ilimReq), .startReq(startReq), .fltN(fltN),
    .syncPullDown(syncPullDown), .faultCause(faultCause));

  // Reference model: 0 run, 1 held, 2 signalling, 3 waiting, 4 failsafe
  int mState = 0, mTmr = 0, mGs = 0, mIms = 0, mCause = 0;
  bit mSwPrev = 0;
  bit clrM, badM, ownM, syncM, swM;
  int codeM;

  function automatic bit modelSw();
    bit bad = !biasOk || !enShdn || !enUvlo || !vinOk || vinOv;
    return (mState == 0) && !bad && !flags[12] && !(modeSec && flags[3]);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mTmr = 0; mGs = 0; mIms = 0; mCause = 0; mSwPrev = 0;
    end else begin
      clrM = !biasOk || !enShdn;
      badM = clrM || !enUvlo || !vinOk || vinOv;
      codeM = 0;
      if (flags[0]) codeM = 1;
      else if (flags[1]) codeM = 2;
      else if (flags[3] && !modeSec) codeM = 3;
      else if (flags[4]) codeM = 4;
      else if (mIms == IMSQ) codeM = 5;
      else if (flags[6]) codeM = 6;
      else if (flags[7]) codeM = 7;
      else if (flags[8]) codeM = 8;
      else if (flags[9]) codeM = 9;
      else if (mGs == GSQ) codeM = 10;
      else if (flags[11]) codeM = 11;
      else if (flags[13] && !badM) codeM = 12;
      ownM  = (codeM >= 1) && (codeM <= 11);
      syncM = (codeM == 12);
      swM = modelSw();
      mSwPrev = swM;
      if (clrM) begin
        mState = 0; mCause = 0; mTmr = 0;
      end else begin
        case (mState)
          0: begin
            mTmr = 0;
            if (ownM) begin mCause = codeM; mState = modeSec ? 2 : 1; end
            else if (syncM) begin mCause = codeM; mState = 1; end
          end
          1: if (autoRetry && !modeSec) begin
               if (mTmr == RETRY - 1) begin mState = 0; mCause = 0; mTmr = 0; end
               else mTmr++;
             end
          2: if (mTmr == PULSE - 1) begin mState = 3; mTmr = 0; end else mTmr++;
          3: if (flags[13]) mState = 1;
             else if (mTmr == SAFE - 1) mState = 4;
             else mTmr++;
          default: ;
        endcase
      end
      mGs  = flags[10] ? ((mGs < GSQ) ? mGs + 1 : GSQ) : 0;
      mIms = flags[5] ? ((mIms < IMSQ) ? mIms + 1 : IMSQ) : 0;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      bit eSw, eIl, eSt, eFl, eSy;
      eSw = modelSw();
      eIl = (mState == 0) && (flags[2] || (modeSec && flags[3]));
      eSt = eSw && !mSwPrev;
      eFl = (mState == 0) && !flags[12] && !flags[2];
      eSy = (mState == 2) || (mState == 4);
      checks++;
      if (swEn !== eSw || ilimReq !== eIl || startReq !== eSt || fltN !== eFl ||
          syncPullDown !== eSy || faultCause !== 4'(mCause)) begin
        errors++;
        $display("FAIL %s model compare at %0t: act sw=%b il=%b st=%b flt=%b sy=%b c=%0d exp sw=%b il=%b st=%b flt=%b sy=%b c=%0d",
          curReq, $time, swEn, ilimReq, startReq, fltN, syncPullDown, faultCause,
          eSw, eIl, eSt, eFl, eSy, mCause);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doClear();
    enShdn = 1'b0;
    step(2);
    enShdn = 1'b1;
    step(3);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    // R1 reset state
    chk("R1", "fltN in reset", int'(fltN), 1);
    chk("R1", "cause in reset", int'(faultCause), 0);
    rstN = 1'b1;
    #1;
    chk("R1", "startReq after release", int'(startReq), 1);
    step(2);
    chk("R1", "swEn running", int'(swEn), 1);
    chk("R1", "startReq single", int'(startReq), 0);

    // R3 overvoltage: off, no fault pin, restart pulse
    curReq = "R3";
    vinOv = 1'b1; step(3);
    chk("R3", "swEn under OV", int'(swEn), 0);
    chk("R3", "fltN under OV", int'(fltN), 1);
    vinOv = 1'b0; #1;
    chk("R3", "startReq on return", int'(startReq), 1);
    step(1);
    vinOk = 1'b0; step(2);
    chk("R3", "swEn under input UV", int'(swEn), 0);
    vinOk = 1'b1; step(2);
    chk("R3", "cause after UV", int'(faultCause), 0);

    // R4 start-up overcurrent
    curReq = "R4";
    flags[2] = 1'b1; step(2);
    chk("R4", "ilimReq", int'(ilimReq), 1);
    chk("R4", "swEn kept", int'(swEn), 1);
    chk("R4", "fltN low", int'(fltN), 0);
    flags[2] = 1'b0; step(2);
    chk("R4", "fltN released", int'(fltN), 1);

    // R5 drain-source health
    curReq = "R5";
    flags[12] = 1'b1; step(2);
    chk("R5", "swEn off", int'(swEn), 0);
    chk("R5", "fltN low", int'(fltN), 0);
    flags[12] = 1'b0; step(2);
    chk("R5", "swEn back", int'(swEn), 1);
    chk("R5", "not held", int'(faultCause), 0);

    // R2 overtemperature held after flag drops
    curReq = "R2";
    flags[0] = 1'b1; step(1);
    flags[0] = 1'b0; step(3);
    chk("R2", "swEn held off", int'(swEn), 0);
    chk("R2", "fltN held low", int'(fltN), 0);
    chk("R2", "cause overtemp", int'(faultCause), 1);

    // R10 UVLO-only drop does not clear; shutdown drop does
    curReq = "R10";
    enUvlo = 1'b0; step(3);
    enUvlo = 1'b1; step(2);
    chk("R10", "UVLO drop keeps cause", int'(faultCause), 1);
    enShdn = 1'b0; step(2);
    chk("R10", "shutdown drop clears", int'(faultCause), 0);
    enShdn = 1'b1; step(2);
    chk("R10", "swEn after clear", int'(swEn), 1);
    biasOk = 1'b0; step(1); biasOk = 1'b1; step(2);

    // R12 priority and first cause held
    curReq = "R12";
    flags[8] = 1'b1; flags[6] = 1'b1; step(1);
    flags = '0; step(2);
    chk("R12", "lowest code wins", int'(faultCause), 6);
    flags[0] = 1'b1; step(2); flags = '0; step(1);
    chk("R12", "first cause held", int'(faultCause), 6);
    doClear();

    // R11 qualification windows
    curReq = "R11";
    flags[10] = 1'b1; step(GSQ - 1);
    flags[10] = 1'b0; step(2);
    chk("R11", "short gate-source ignored", int'(faultCause), 0);
    flags[10] = 1'b1; step(GSQ + 2);
    flags[10] = 1'b0; step(1);
    chk("R11", "gate-source qualified", int'(faultCause), 10);
    doClear();
    flags[5] = 1'b1; step(IMSQ - 1);
    flags[5] = 1'b0; step(2);
    chk("R11", "short monitor short ignored", int'(fltN), 1);
    flags[5] = 1'b1; step(IMSQ + 2);
    flags[5] = 1'b0; step(1);
    chk("R11", "monitor short qualified", int'(faultCause), 5);
    doClear();

    // R7 sync low only counts outside UV/OV
    curReq = "R7";
    vinOk = 1'b0; flags[13] = 1'b1; step(3);
    chk("R7", "sync during UV ignored", int'(faultCause), 0);
    chk("R7", "fltN during UV", int'(fltN), 1);
    vinOk = 1'b1; step(1);
    flags[13] = 1'b0; step(2);
    chk("R7", "sync fault held", int'(faultCause), 12);
    doClear();

    // R8 auto-retry and latch-off
    curReq = "R8";
    autoRetry = 1'b1;
    flags[9] = 1'b1; step(1); flags[9] = 1'b0; step(3);
    chk("R8", "held before retry", int'(swEn), 0);
    step(RETRY);
    chk("R8", "retry restores swEn", int'(swEn), 1);
    chk("R8", "retry clears cause", int'(faultCause), 0);
    autoRetry = 1'b0;
    flags[1] = 1'b1; step(1); flags[1] = 1'b0; step(RETRY + 5);
    chk("R8", "latch-off stays off", int'(swEn), 0);
    doClear();

    // R6 secondary short: trip and limited restart, not held
    curReq = "R6";
    modeSec = 1'b1; step(2);
    flags[3] = 1'b1; step(2);
    chk("R6", "swEn off", int'(swEn), 0);
    chk("R6", "ilimReq", int'(ilimReq), 1);
    chk("R6", "fltN high", int'(fltN), 1);
    flags[3] = 1'b0; step(2);
    chk("R6", "swEn back", int'(swEn), 1);
    chk("R6", "not held", int'(faultCause), 0);

    // R9 secondary signalling, answered
    curReq = "R9";
    flags[0] = 1'b1; step(1); flags[0] = 1'b0; #1;
    chk("R9", "pulse active", int'(syncPullDown), 1);
    step(PULSE + 1);
    chk("R9", "pulse ended", int'(syncPullDown), 0);
    chk("R9", "fltN during wait", int'(fltN), 0);
    flags[13] = 1'b1; step(1); flags[13] = 1'b0; step(SAFE + 3);
    chk("R9", "answered: no failsafe", int'(syncPullDown), 0);
    chk("R9", "answered: cause", int'(faultCause), 1);
    biasOk = 1'b0; step(2); biasOk = 1'b1; step(3);
    chk("R9", "clear restores swEn", int'(swEn), 1);

    // R9 unanswered: failsafe latch-off
    flags[11] = 1'b1; step(1); flags[11] = 1'b0;
    step(PULSE + SAFE + 4);
    chk("R9", "failsafe pulls sync", int'(syncPullDown), 1);
    chk("R9", "failsafe swEn off", int'(swEn), 0);
    step(10);
    chk("R9", "failsafe persists", int'(syncPullDown), 1);
    curReq = "R10";
    doClear();
    chk("R10", "failsafe cleared", int'(syncPullDown), 0);
    chk("R10", "swEn after failsafe clear", int'(swEn), 1);
    modeSec = 1'b0; step(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule